// File: doc/BRIEF.md
# Per-Core Countdown Timer with Power-of-Sixteen Prescaler

This block is a private 32-bit down-counting timer for a single processor core. Software programs it through a small register port that takes whole 32-bit words: a reload value, the live count, a control word and an interrupt status word. While enabled, the count drops by one on every prescaled tick. When the count expires, a raw event flag is set, and if interrupts are enabled a pending flag is set as well. The pending flag drives a level interrupt request towards the core's interrupt controller.

The prescaler divides the input clock by sixteen raised to a two-bit selector, so one tick takes 1, 16, 256 or 4096 clocks. Counting restarts on three events: a write of the reload value, a direct write of the count, and a control write that turns the timer on. When the count expires, the timer either reloads itself or stops at zero. A write of any data to the status word clears both flags. Reads and writes take effect on the clock edge where `rd_en` or `wr_en` is sampled high. Read data is combinational from the current state.

Top module: `core_countdown_timer`

## Requirements
- R1: After a synchronous reset every register reads 0 and `irq` is low.
- R2: A write to offset 0x00 stores the reload value and, at that same edge, sets the count to the written value and restarts the prescale phase.
- R3: A write to offset 0x04 sets the count to the written value and leaves the stored reload value unchanged.
- R4: A control write (offset 0x08) that changes enable (bit 0) from 0 to 1 sets the count to the stored reload value. A control write that finds enable already set leaves the count unchanged.
- R5: While enabled, the count drops by one once every 16^S clocks, where S is control bits [15:8] saturated to 3 and read back saturated. Any control write restarts the prescale phase. While disabled the count holds.
- R6: A tick that finds the count at 1 is an expiry. An expiry always sets the raw flag. It sets the pending flag, which is driven out as `irq`, only if interrupt enable (control bit 2) is 1.
- R7: On expiry the count becomes the reload value if auto-reload (control bit 1) is 1, and 0 otherwise. A count of 0 never expires and stays at 0.
- R8: Any write to offset 0x0C clears the raw and pending flags, whatever the data. If an expiry falls in the same cycle, the expiry wins. A read of 0x0C returns the raw flag in bit 0 and zeros elsewhere.
- R9: A read of offset 0x04 returns the current remaining count.
- R10: Offsets other than 0x00, 0x04, 0x08 and 0x0C read as 0, and writes to them change nothing. `rdata` is 0 whenever `rd_en` is low.
- R11: A register write that restarts the count takes priority over a tick in the same cycle. No decrement is applied on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (4) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, 0 when no read |
| irq | output | 1 | Level interrupt request (pending flag) |

## Verification
The bench uses the default parameters: 32-bit data, a 4-bit offset and a prescale ceiling of 3. The 4-bit offset gives sixteen offsets, so random traffic regularly lands on the twelve undefined offsets, including the misaligned ones. With a ceiling of 3, all four divide ratios can be selected, and an oversized prescale field exercises the saturation rule. The directed sequences pin down exact expiry cycles at divide-by-16, the restart-versus-tick priority, and both reload modes. Random register traffic with short reload values then hits many expiries that coincide with status clears and control writes.

// File: rtl/ctimer_pkg.sv
// Package: shared offsets, control field positions and the control word type
// for the per-core countdown timer.
package ctimer_pkg;

    localparam int CT_DATA_W = 32;
    localparam int CT_SEL_W  = 2;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFF_RELOAD = 8'h00;
    localparam logic [7:0] OFF_COUNT  = 8'h04;
    localparam logic [7:0] OFF_CTRL   = 8'h08;
    localparam logic [7:0] OFF_STAT   = 8'h0C;

    // Control word bit positions
    localparam int BIT_EN    = 0;
    localparam int BIT_AR    = 1;
    localparam int BIT_IE    = 2;
    localparam int PSC_LSB   = 8;
    localparam int PSC_W     = 8;

    typedef struct packed {
        logic [CT_SEL_W-1:0] psc;
        logic                ie;
        logic                ar;
        logic                en;
    } ctl_t;

    // Build the 32-bit read image of a control value
    function automatic logic [CT_DATA_W-1:0] ctl_image(input ctl_t c);
        logic [CT_DATA_W-1:0] w;
        w = '0;
        w[BIT_EN] = c.en;
        w[BIT_AR] = c.ar;
        w[BIT_IE] = c.ie;
        w[PSC_LSB +: CT_SEL_W] = c.psc;
        return w;
    endfunction

endpackage

// File: rtl/ctimer_regs.sv
// Module: ctimer_regs
// Decodes the register port, holds the reload value and control word, and
// drives read data. It produces one-cycle strobes for the other sub-blocks.
// Assumes one access per cycle and whole-word accesses.
module ctimer_regs
    import ctimer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int PSC_MAX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              raw_q,
    output ctl_t              ctl_q,
    output logic [DATA_W-1:0] reload_q,
    output logic              wr_reload,
    output logic              wr_count,
    output logic              wr_ctrl,
    output logic              wr_stat,
    output logic              en_rise,
    output logic [DATA_W-1:0] rdata
);

    logic              hit_reload, hit_count, hit_ctrl, hit_stat;
    logic [PSC_W-1:0]  psc_field;
    logic [CT_SEL_W-1:0] psc_sat;
    logic [CT_DATA_W-1:0] ctl_word;

    // Offset decode
    always_comb begin
        hit_reload = (addr == ADDR_W'(OFF_RELOAD));
        hit_count  = (addr == ADDR_W'(OFF_COUNT));
        hit_ctrl   = (addr == ADDR_W'(OFF_CTRL));
        hit_stat   = (addr == ADDR_W'(OFF_STAT));
    end

    // Write strobes per register
    always_comb begin
        wr_reload = wr_en && hit_reload;
        wr_count  = wr_en && hit_count;
        wr_ctrl   = wr_en && hit_ctrl;
        wr_stat   = wr_en && hit_stat;
        en_rise   = wr_ctrl && !ctl_q.en && wdata[BIT_EN];
    end

    // Saturate the written prescale selector to the supported ceiling
    always_comb begin
        psc_field = wdata[PSC_LSB +: PSC_W];
        if (psc_field > PSC_W'(PSC_MAX))
            psc_sat = CT_SEL_W'(PSC_MAX);
        else
            psc_sat = psc_field[CT_SEL_W-1:0];
    end

    // Reload value register
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (wr_reload)
            reload_q <= wdata;
    end

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctrl) begin
            ctl_q.en  <= wdata[BIT_EN];
            ctl_q.ar  <= wdata[BIT_AR];
            ctl_q.ie  <= wdata[BIT_IE];
            ctl_q.psc <= psc_sat;
        end
    end

    assign ctl_word = ctl_image(ctl_q);

    // Read multiplexer; zero when idle or at an undefined offset
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit_reload)      rdata = reload_q;
            else if (hit_count)  rdata = cnt_q;
            else if (hit_ctrl)   rdata = DATA_W'(ctl_word);
            else if (hit_stat)   rdata = DATA_W'(raw_q);
        end
    end

endmodule

// File: rtl/ctimer_prescale.sv
// Module: ctimer_prescale
// Generates one tick every 16^psc clocks while running. The phase counter
// clears whenever clr is high or the timer is stopped. No tick is issued in a
// cycle with clr. Assumes psc never exceeds PSC_MAX.
module ctimer_prescale
    import ctimer_pkg::*;
#(
    parameter int PSC_MAX = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                clr,
    input  logic [CT_SEL_W-1:0] psc,
    output logic                tick
);

    localparam int DIV_W = (PSC_MAX == 0) ? 1 : 4 * PSC_MAX;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] lim_tab [0:PSC_MAX];
    logic [DIV_W-1:0] lim_sel;

    // Terminal phase value for each selector setting
    for (genvar g = 0; g <= PSC_MAX; g++) begin : g_lim
        localparam int unsigned LIM = (32'd1 << (4 * g)) - 32'd1;
        assign lim_tab[g] = LIM[DIV_W-1:0];
    end

    assign lim_sel = lim_tab[psc];
    assign tick    = run && !clr && (phase_q == lim_sel);

    // Phase counter advance and clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (!run || clr || tick)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

endmodule

// File: rtl/ctimer_count.sv
// Module: ctimer_count
// The remaining-count register. A restart loads restart_val and overrides any
// tick. A tick at count 1 is an expiry, which reloads or stops at zero. A tick
// at count 0 does nothing.
module ctimer_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DATA_W-1:0] restart_val,
    input  logic              tick,
    input  logic              reload_en,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] cnt_d;

    assign expire = tick && !restart && (cnt_q == ONE);

    // Next-count selection
    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = restart_val;
        else if (expire)
            cnt_d = reload_en ? reload_val : '0;
        else if (tick && (cnt_q != '0))
            cnt_d = cnt_q - ONE;
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ctimer_flags.sv
// Module: ctimer_flags
// Raw and pending interrupt flags. An expiry sets them; a status write clears
// them, and an expiry in the same cycle wins over the clear.
module ctimer_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic int_en,
    input  logic clear,
    output logic raw_q,
    output logic pend_q
);

    // Raw event flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else if (expire)
            raw_q <= 1'b1;
        else if (clear)
            raw_q <= 1'b0;
    end

    // Pending flag, gated by interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (expire && int_en)
            pend_q <= 1'b1;
        else if (clear)
            pend_q <= 1'b0;
    end

endmodule

// File: rtl/core_countdown_timer.sv
// Module: core_countdown_timer
// Top level of a per-core countdown timer. It joins the register file, the
// prescaler, the count register and the interrupt flags. irq comes straight
// from the pending-flag register. Assumes PSC_MAX <= 3 and 4 <= ADDR_W <= 8.
module core_countdown_timer
    import ctimer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int PSC_MAX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    ctl_t              ctl_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] restart_val;
    logic              wr_reload, wr_count, wr_ctrl, wr_stat, en_rise;
    logic              restart, phase_clr, tick, expire;
    logic              raw_q, pend_q;

    ctimer_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .PSC_MAX(PSC_MAX)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt_q    (cnt_q),
        .raw_q    (raw_q),
        .ctl_q    (ctl_q),
        .reload_q (reload_q),
        .wr_reload(wr_reload),
        .wr_count (wr_count),
        .wr_ctrl  (wr_ctrl),
        .wr_stat  (wr_stat),
        .en_rise  (en_rise),
        .rdata    (rdata)
    );

    // Restart sources and value: written data wins, otherwise the reload value
    always_comb begin
        restart     = wr_reload || wr_count || en_rise;
        phase_clr   = restart || wr_ctrl;
        restart_val = (wr_reload || wr_count) ? wdata : reload_q;
    end

    ctimer_prescale #(
        .PSC_MAX(PSC_MAX)
    ) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctl_q.en),
        .clr  (phase_clr),
        .psc  (ctl_q.psc),
        .tick (tick)
    );

    ctimer_count #(
        .DATA_W(DATA_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .restart_val(restart_val),
        .tick       (tick),
        .reload_en  (ctl_q.ar),
        .reload_val (reload_q),
        .cnt_q      (cnt_q),
        .expire     (expire)
    );

    ctimer_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .expire(expire),
        .int_en(ctl_q.ie),
        .clear (wr_stat),
        .raw_q (raw_q),
        .pend_q(pend_q)
    );

    assign irq = pend_q;

endmodule

// File: rtl/ctimer_checker.sv
// Module: ctimer_checker
// Temporal properties of the countdown timer, bound to the top module.
module ctimer_checker
    import ctimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] cnt_q,
    input logic              en,
    input logic              raw_q,
    input logic              irq,
    input logic              expire
);

    // R1: state is clear on the first edge after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cnt_q == '0 && !irq && !raw_q));

    // R2: a reload write sets the count to the written word
    a_r2_reload_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_RELOAD)) |=> (cnt_q == $past(wdata)));

    // R5: a stopped timer holds its count without writes
    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_en) |=> $stable(cnt_q));

    // R6: the request never stands without the raw flag
    a_r6_irq_has_raw: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw_q);

    // R7: a count of zero stays at zero without writes
    a_r7_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !wr_en) |=> (cnt_q == '0));

    // R8: a status write without a coincident expiry clears both flags
    a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_STAT) && !expire) |=> (!irq && !raw_q));

    // R11: without writes the count falls by at most one per cycle below reload
    a_r11_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt_q > DATA_W'(1)) |=>
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - DATA_W'(1)));

endmodule

bind core_countdown_timer ctimer_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .cnt_q (cnt_q),
    .en    (ctl_q.en),
    .raw_q (raw_q),
    .irq   (irq),
    .expire(expire)
);

// File: tb/core_countdown_timer_bench.sv
// Bench: directed corner cases plus seeded random register traffic, checked
// against a reference model written from the requirements.
module core_countdown_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int PMAX = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] last_rd;

    // Reference state
    logic [DW-1:0] m_reload, m_cnt;
    logic          m_en, m_ar, m_ie, m_raw, m_pend;
    logic [1:0]    m_psc;
    int unsigned   m_phase;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_countdown_timer #(.DATA_W(DW), .ADDR_W(AW), .PSC_MAX(PMAX)) u_core_countdown_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [1:0] sat_psc(input logic [DW-1:0] d);
        return (d[15:8] > 8'(PMAX)) ? 2'(PMAX) : d[9:8];
    endfunction

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        case (a)
            4'h0: return m_reload;
            4'h4: return m_cnt;
            4'h8: return {22'b0, m_psc, 5'b0, m_ie, m_ar, m_en};
            4'hC: return {31'b0, m_raw};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [AW-1:0] a);
        case (a)
            4'h0: return "R2 reload read";
            4'h4: return "R9 count read";
            4'h8: return "R5 control read";
            4'hC: return "R8 status read";
            default: return "R10 undefined read";
        endcase
    endfunction

    // Reference model, advanced on each clock edge from the requirements
    always @(posedge clk) begin
        logic wl, wc, wctl, wst, rise, rst_cnt, clr, tk, ex;
        logic [DW-1:0] nc;
        if (!rst_n) begin
            m_reload <= '0; m_cnt <= '0; m_en <= 0; m_ar <= 0; m_ie <= 0;
            m_psc <= '0; m_raw <= 0; m_pend <= 0; m_phase <= 0;
        end else begin
            wl   = wr_en && addr == 4'h0;
            wc   = wr_en && addr == 4'h4;
            wctl = wr_en && addr == 4'h8;
            wst  = wr_en && addr == 4'hC;
            rise = wctl && !m_en && wdata[0];
            rst_cnt = wl || wc || rise;
            clr  = rst_cnt || wctl;
            tk   = m_en && !clr && (m_phase == (32'd1 << (4 * m_psc)) - 1);
            ex   = tk && m_cnt == 1;
            nc = m_cnt;
            if (rst_cnt) nc = (wl || wc) ? wdata : m_reload;
            else if (ex) nc = m_ar ? m_reload : '0;
            else if (tk && m_cnt != 0) nc = m_cnt - 1;
            m_cnt   <= nc;
            m_phase <= (!m_en || clr || tk) ? 0 : m_phase + 1;
            if (wl) m_reload <= wdata;
            if (wctl) begin
                m_en <= wdata[0]; m_ar <= wdata[1]; m_ie <= wdata[2];
                m_psc <= sat_psc(wdata);
            end
            if (ex) m_raw <= 1'b1; else if (wst) m_raw <= 1'b0;
            if (ex && m_ie) m_pend <= 1'b1; else if (wst) m_pend <= 1'b0;
        end
    end

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: check irq, drive, check read data, pass one edge
    task automatic cyc(input logic w, input logic r, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        chk(DW'(irq), DW'(m_pend), "R6 irq level");
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        if (r) begin
            last_rd = rdata;
            chk(rdata, model_read(a), tag_of(a));
        end
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, '0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 4; k++) begin
            cyc(0, 1, AW'(k * 4), '0);
            chk(last_rd, '0, "R1 register after reset");
        end
        chk(DW'(irq), '0, "R1 irq after reset");

        // R4 / R11 / R3: restart rules
        cyc(1, 0, 4'h8, 32'h1);
        cyc(1, 0, 4'h0, 32'd50);
        idle(4);
        cyc(1, 0, 4'h8, 32'h1);
        cyc(0, 1, 4'h4, '0);
        chk(last_rd, 32'd46, "R4 enable kept set, no restart");
        cyc(1, 0, 4'h8, 32'h0);
        cyc(1, 0, 4'h8, 32'h1);
        cyc(0, 1, 4'h4, '0);
        chk(last_rd, 32'd50, "R4 enable rise restarts from reload");
        cyc(1, 0, 4'h4, 32'd7);
        cyc(0, 1, 4'h4, '0);
        chk(last_rd, 32'd7, "R11 write wins over tick");
        cyc(0, 1, 4'h0, '0);
        chk(last_rd, 32'd50, "R3 count write keeps reload");

        // R7: auto-reload
        cyc(1, 0, 4'h8, 32'h0);
        cyc(1, 0, 4'hC, 32'h0);
        cyc(1, 0, 4'h0, 32'd3);
        cyc(1, 0, 4'h8, 32'h7);
        idle(3);
        chk(DW'(irq), 32'd1, "R7 expiry raised irq");
        cyc(0, 1, 4'h4, '0);
        chk(last_rd, 32'd3, "R7 reloaded on expiry");

        // R7 / R8: one-shot, then clear
        cyc(1, 0, 4'h8, 32'h0);
        cyc(1, 0, 4'hC, 32'hFFFF_FFFF);
        chk(DW'(irq), '0, "R8 status write clears irq");
        cyc(1, 0, 4'h0, 32'd2);
        cyc(1, 0, 4'h8, 32'h5);
        idle(5);
        cyc(0, 1, 4'h4, '0);
        chk(last_rd, '0, "R7 one-shot stops at zero");
        cyc(0, 1, 4'hC, '0);
        chk(last_rd, 32'd1, "R8 raw flag in bit 0");
        cyc(1, 0, 4'hC, 32'h0);
        cyc(0, 1, 4'hC, '0);
        chk(last_rd, '0, "R8 zero data still clears raw");
        chk(DW'(irq), '0, "R8 zero data still clears pending");

        // R6: interrupt enable off
        cyc(1, 0, 4'h8, 32'h0);
        cyc(1, 0, 4'h0, 32'd1);
        cyc(1, 0, 4'h8, 32'h1);
        idle(1);
        chk(DW'(irq), '0, "R6 no irq with enable off");
        cyc(0, 1, 4'hC, '0);
        chk(last_rd, 32'd1, "R6 raw set with enable off");

        // R5: divide by 16 timing
        cyc(1, 0, 4'h8, 32'h0);
        cyc(1, 0, 4'hC, 32'h0);
        cyc(1, 0, 4'h0, 32'd3);
        cyc(1, 0, 4'h8, 32'h107);
        idle(47);
        chk(DW'(irq), '0, "R5 no expiry before 48 clocks");
        idle(1);
        chk(DW'(irq), 32'd1, "R5 expiry at 48 clocks");

        // R5: saturation and hold while off
        cyc(1, 0, 4'h8, 32'h0000_FF00);
        cyc(0, 1, 4'h8, '0);
        chk(last_rd, 32'h300, "R5 prescale saturates to 3");
        cyc(1, 0, 4'h4, 32'd9);
        idle(20);
        cyc(0, 1, 4'h4, '0);
        chk(last_rd, 32'd9, "R5 count holds while off");

        // R10: undefined offsets
        cyc(1, 0, 4'h1, 32'hDEAD_BEEF);
        cyc(1, 0, 4'hD, 32'hDEAD_BEEF);
        cyc(0, 1, 4'h0, '0);
        chk(last_rd, 32'd3, "R10 undefined write ignored");
        cyc(0, 1, 4'h2, '0);
        chk(last_rd, '0, "R10 undefined read is zero");
        #1 chk(rdata, '0, "R10 rdata zero without read");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned op = $urandom % 100;
            logic [AW-1:0] a = AW'($urandom);
            logic [DW-1:0] d;
            if (op < 55) begin
                idle(1);
            end else if (op < 75) begin
                cyc(0, 1, a, '0);
            end else begin
                if ($urandom % 4 != 0) a = AW'(($urandom % 4) * 4);
                case (a)
                    4'h8: d = {16'b0, ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 2),
                               5'b0, 3'($urandom)};
                    4'h0, 4'h4: d = $urandom % 21;
                    default: d = $urandom;
                endcase
                cyc(1, 0, a, d);
            end
        end

        finish_run();
    end

endmodule